// File: doc/BRIEF.md
# Configurable Synchronous Serial Port

This block moves parallel words of 4 to 16 bits over a four-wire synchronous serial link. It can act as the clock master or follow a clock and frame signal from outside. The transmit side has a one-word holding buffer behind a valid/ready handshake. Each received word is presented right-aligned and held until the consumer accepts it.

Three registers set up the port: a format word, a mode word and a clock prescaler. Two framings are available. One is the common SPI scheme with selectable clock polarity and phase. The other is a pulsed-frame scheme, where a one-period frame strobe comes just before the first data bit. As master, the serial clock is the system clock divided by two cascaded factors: an even prescale value, then one plus an 8-bit rate value. As slave, the port can drive its data line, or it can keep the driver off and only listen.

Top module: `ssp_core`

## Requirements
- R1: After reset the format word reads 0x0000, the mode word reads 0x0000 and the prescaler reads 2. In this state sclk_o=0, frm_o=1, tx_ready=0, rx_valid=0 and sdo_en=0.
- R2: As master, each serial clock level lasts (PS/2)*(1+RATE) system cycles, so the full period is PS*(1+RATE). PS is the prescaler and RATE is format-word bits 15:8.
- R3: Master SPI framing (format code 2'b00). frm_o stays low for the whole frame. sclk_o idles at format-word bit 6 (polarity). Format-word bit 7 (phase) set to 0 captures data on the first clock edge of each bit, and set to 1 on the second edge. Data leaves MSB first. The received word appears right-aligned on rx_data with rx_valid once the frame ends.
- R4: The frame length is format-word bits 3:0 plus one. Codes 0 to 2 give 4-bit frames.
- R5: Bit 0 of the prescaler is always stored as zero. A write that would leave the prescaler at zero is discarded.
- R6: While the enable bit (mode word bit 1) is set, writes to the format word and the prescaler are ignored. A write to the mode word changes only the enable bit.
- R7: Format code 2'b01 selects pulsed framing. The clock idles low. Data changes on rising edges and is sampled on falling edges. frm_o is high for exactly one serial period, ending at the rising edge that starts the MSB. Codes 2'b10 and 2'b11 behave as SPI.
- R8: Mode word bit 2 selects slave. In slave mode the port follows sclk_i and frm_i using the same edge rules. It drives sdo_en high during a frame while mode word bit 3 is clear.
- R9: When mode word bits 2 and 3 are both set, sdo_en stays low throughout, and received frames are still delivered on rx_data.
- R10: tx_ready is high exactly when the port is enabled and the transmit buffer is empty. rx_valid stays high until rx_ready is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 format, 1 mode, 2 prescaler |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Contents of the selected register |
| tx_valid | input | 1 | Transmit word offered |
| tx_data | input | 16 | Transmit word, right-aligned |
| tx_ready | output | 1 | Transmit buffer can accept a word |
| rx_valid | output | 1 | Received word held |
| rx_data | output | 16 | Received word, right-aligned |
| rx_ready | input | 1 | Consumer takes the received word |
| sclk_o | output | 1 | Serial clock driven as master |
| frm_o | output | 1 | Select (SPI) or frame strobe (pulsed) driven as master |
| sclk_i | input | 1 | Serial clock from outside in slave mode |
| frm_i | input | 1 | Select or strobe from outside in slave mode |
| sdo | output | 1 | Serial data out |
| sdo_en | output | 1 | Output driver enable for sdo |
| sdi | input | 1 | Serial data in |

## Verification
Register readback is combinational and is checked in the same cycle as the write that precedes it. A word accepted on tx starts a master frame at the next edge. The first serial edge then comes one level time, (PS/2)*(1+RATE) cycles, later, and rx_valid rises one cycle after the final level time. The checks therefore do not predict absolute edge times. They sample on falling system-clock edges, detect each serial transition and count the cycles between transitions against the formula. In slave mode the port sees each external edge three system cycles late, through a two-stage synchronizer and an edge detector. The bench holds every serial level for eight cycles, so sdo is read and sdi is changed well clear of that window.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int WORD_W = 16;
  localparam int CNT_W  = 6;
  localparam int PSC_W  = 8;

  localparam logic [1:0] A_FMT  = 2'd0;
  localparam logic [1:0] A_MODE = 2'd1;
  localparam logic [1:0] A_PSC  = 2'd2;

  localparam logic [1:0] FMT_PULSE = 2'b01;

  typedef struct packed {
    logic [7:0] rate;
    logic       ph;
    logic       pol;
    logic [1:0] fmt;
    logic [3:0] size;
  } fmtw_t;
endpackage

// File: rtl/ssp_regs.sv
module ssp_regs
  import ssp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output fmtw_t             fmtw,
  output logic              en,
  output logic              slave,
  output logic              odis,
  output logic [PSC_W-1:0]  psc
);
  fmtw_t            fmt_q, fmt_d;
  logic [2:0]       md_q, md_d;   // {odis, slave, en}
  logic [PSC_W-1:0] psc_q, psc_d, psc_w;

  always_comb begin
    fmt_d = fmt_q;
    md_d  = md_q;
    psc_d = psc_q;
    psc_w = {wdata[PSC_W-1:1], 1'b0};
    if (we) begin
      unique case (addr)
        A_FMT:   if (!md_q[0]) fmt_d = fmtw_t'(wdata);
        A_MODE:  md_d = md_q[0] ? {md_q[2:1], wdata[1]} : {wdata[3], wdata[2], wdata[1]};
        A_PSC:   if (!md_q[0] && psc_w != '0) psc_d = psc_w;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q <= '0;
      md_q  <= '0;
      psc_q <= PSC_W'(2);
    end else begin
      fmt_q <= fmt_d;
      md_q  <= md_d;
      psc_q <= psc_d;
    end
  end

  always_comb begin
    unique case (addr)
      A_FMT:   rdata = fmt_q;
      A_MODE:  rdata = {{(WORD_W-4){1'b0}}, md_q, 1'b0};
      A_PSC:   rdata = {{(WORD_W-PSC_W){1'b0}}, psc_q};
      default: rdata = '0;
    endcase
  end

  assign fmtw  = fmt_q;
  assign en    = md_q[0];
  assign slave = md_q[1];
  assign odis  = md_q[2] & md_q[1];
  assign psc   = psc_q;

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> ($stable(fmt_q) && $stable(psc_q) && $stable(md_q[2:1]))); // R6
endmodule

// File: rtl/ssp_baud.sv
module ssp_baud
  import ssp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] psc,
  input  logic [7:0]       rate,
  output logic             tick
);
  logic [PSC_W-2:0] pc_q, pc_d;
  logic [7:0]       rc_q, rc_d;
  logic             pre_wrap;

  always_comb begin
    pre_wrap = (pc_q == psc[PSC_W-1:1] - 1'b1);
    tick     = run && pre_wrap && (rc_q == rate);
    pc_d     = pc_q;
    rc_d     = rc_q;
    if (!run) begin
      pc_d = '0;
      rc_d = '0;
    end else if (pre_wrap) begin
      pc_d = '0;
      rc_d = (rc_q == rate) ? 8'd0 : rc_q + 8'd1;
    end else begin
      pc_d = pc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      rc_q <= '0;
    end else begin
      pc_q <= pc_d;
      rc_q <= rc_d;
    end
  end
endmodule

// File: rtl/ssp_engine.sv
module ssp_engine
  import ssp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              slave,
  input  logic              odis,
  input  fmtw_t             fmtw,
  input  logic              tick,
  input  logic              sclk_i,
  input  logic              frm_i,
  input  logic              sdi,
  input  logic              tx_have,
  input  logic [WORD_W-1:0] tx_word,
  output logic              run,
  output logic              load,
  output logic              done,
  output logic [WORD_W-1:0] rx_next,
  output logic              sclk_o,
  output logic              frm_o,
  output logic              sdo,
  output logic              sdo_en
);
  logic              busy_q, busy_d, tg_q, tg_d, fp_q, fp_d;
  logic [CNT_W-1:0]  k_q, k_d, total, lead, jj;
  logic [WORD_W-1:0] txs_q, txs_d, rxs_q, rxs_d;
  logic [2:0]        syc_q, syf_q;
  logic [4:0]        nbits;
  logic              pulsed, pol, ph, s_edge, s_fall, f_fell, start, ev, samp;

  always_comb begin
    pulsed = (fmtw.fmt == FMT_PULSE);
    pol    = pulsed ? 1'b0 : fmtw.pol;
    ph     = pulsed ? 1'b1 : fmtw.ph;
    nbits  = (fmtw.size < 4'd3) ? 5'd4 : {1'b0, fmtw.size} + 5'd1;
    lead   = pulsed ? CNT_W'(2) : CNT_W'(0);
    total  = {nbits, 1'b0} + lead;
    s_edge = syc_q[1] ^ syc_q[2];
    s_fall = syc_q[2] & ~syc_q[1];
    f_fell = syf_q[2] & ~syf_q[1];
    start  = en & ~busy_q & (slave ? (pulsed ? (s_fall & syf_q[1]) : f_fell) : tx_have);
    ev     = busy_q & (slave ? s_edge : (tick & (k_q != total)));
    jj     = k_q - lead;
    samp   = (jj[0] == ph);
    done   = busy_q & (slave ? (ev & (k_q == total - 1'b1)) : (tick & (k_q == total)));
    load   = start & tx_have;
  end

  always_comb begin
    busy_d = busy_q;
    k_d    = k_q;
    tg_d   = tg_q;
    fp_d   = fp_q;
    txs_d  = txs_q;
    rxs_d  = rxs_q;
    if (!en) begin
      busy_d = 1'b0;
      tg_d   = 1'b0;
      fp_d   = 1'b0;
    end else if (start) begin
      busy_d = 1'b1;
      k_d    = (slave && pulsed) ? CNT_W'(2) : CNT_W'(0);
      tg_d   = 1'b0;
      fp_d   = 1'b0;
      txs_d  = tx_have ? (tx_word << (WORD_W - int'(nbits))) : '0;
      rxs_d  = '0;
    end else if (ev) begin
      k_d  = k_q + 1'b1;
      tg_d = ~tg_q;
      if (k_q == '0)           fp_d = pulsed;
      else if (k_q == CNT_W'(2)) fp_d = 1'b0;
      if (k_q >= lead) begin
        if (samp)          rxs_d = {rxs_q[WORD_W-2:0], sdi};
        else if (jj != '0) txs_d = txs_q << 1;
      end
      if (done) busy_d = 1'b0;
    end else if (done) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      k_q    <= '0;
      tg_q   <= 1'b0;
      fp_q   <= 1'b0;
      txs_q  <= '0;
      rxs_q  <= '0;
      syc_q  <= '0;
      syf_q  <= '1;
    end else begin
      busy_q <= busy_d;
      k_q    <= k_d;
      tg_q   <= tg_d;
      fp_q   <= fp_d;
      txs_q  <= txs_d;
      rxs_q  <= rxs_d;
      syc_q  <= {syc_q[1:0], sclk_i};
      syf_q  <= {syf_q[1:0], frm_i};
    end
  end

  assign rx_next = rxs_d;
  assign run     = busy_q & ~slave;
  assign sclk_o  = pol ^ (run & tg_q);
  assign frm_o   = run ? (pulsed & fp_q) : ~pulsed;
  assign sdo     = txs_q[WORD_W-1];
  assign sdo_en  = en & (slave ? (busy_q & ~odis) : 1'b1);

  AST_SEL_LOW:  assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !slave && !pulsed) |-> !frm_o); // R3
  AST_CLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q || slave) |-> (sclk_o == pol)); // R3
endmodule

// File: rtl/ssp_core.sv
module ssp_core
  import ssp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  input  logic              tx_valid,
  input  logic [WORD_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_data,
  input  logic              rx_ready,
  output logic              sclk_o,
  output logic              frm_o,
  input  logic              sclk_i,
  input  logic              frm_i,
  output logic              sdo,
  output logic              sdo_en,
  input  logic              sdi
);
  fmtw_t             fmtw;
  logic              en, slave, odis, run, tick, load, done;
  logic [PSC_W-1:0]  psc;
  logic [WORD_W-1:0] rx_next, txb_q, txb_d, rxb_q, rxb_d;
  logic              txf_q, txf_d, rxv_q, rxv_d, push;

  ssp_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .fmtw(fmtw), .en(en), .slave(slave), .odis(odis), .psc(psc)
  );

  ssp_baud u_baud (
    .clk(clk), .rst_n(rst_n), .run(run), .psc(psc), .rate(fmtw.rate), .tick(tick)
  );

  ssp_engine u_eng (
    .clk(clk), .rst_n(rst_n), .en(en), .slave(slave), .odis(odis), .fmtw(fmtw),
    .tick(tick), .sclk_i(sclk_i), .frm_i(frm_i), .sdi(sdi), .tx_have(txf_q),
    .tx_word(txb_q), .run(run), .load(load), .done(done), .rx_next(rx_next),
    .sclk_o(sclk_o), .frm_o(frm_o), .sdo(sdo), .sdo_en(sdo_en)
  );

  always_comb begin
    push  = tx_valid & tx_ready;
    txb_d = push ? tx_data : txb_q;
    txf_d = push ? 1'b1 : (load ? 1'b0 : txf_q);
    rxb_d = done ? rx_next : rxb_q;
    rxv_d = done ? 1'b1 : (rx_ready ? 1'b0 : rxv_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txb_q <= '0;
      txf_q <= 1'b0;
      rxb_q <= '0;
      rxv_q <= 1'b0;
    end else begin
      txb_q <= txb_d;
      txf_q <= txf_d;
      rxb_q <= rxb_d;
      rxv_q <= rxv_d;
    end
  end

  assign tx_ready = en & ~txf_q;
  assign rx_valid = rxv_q;
  assign rx_data  = rxb_q;

  AST_RX_HOLD:  assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid); // R10
  AST_TX_EN:    assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> en); // R10
  AST_OD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (slave && odis) |-> !sdo_en); // R9
endmodule

// File: tb/sim_ssp_core.sv
module sim_ssp_core;
  logic        clk, rst_n, cfg_we, tx_valid, rx_ready, sclk_i, frm_i, sdi;
  logic [1:0]  cfg_addr;
  logic [15:0] cfg_wdata, tx_data;
  logic [15:0] cfg_rdata, rx_data;
  logic        tx_ready, rx_valid, sclk_o, frm_o, sdo, sdo_en;
  int n_chk, n_bad;
  bit finished;

  ssp_core u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready), .sclk_o(sclk_o),
    .frm_o(frm_o), .sclk_i(sclk_i), .frm_i(frm_i), .sdo(sdo), .sdo_en(sdo_en), .sdi(sdi)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [15:0] exp);
    cfg_addr = a;
    #1;
    check(req, 32'(cfg_rdata), 32'(exp));
  endtask

  task automatic t_reset;
    rd_chk("R1 fmt", 2'd0, 16'h0000);
    rd_chk("R1 mode", 2'd1, 16'h0000);
    rd_chk("R1 psc", 2'd2, 16'h0002);
    check("R1 sclk", 32'(sclk_o), 0);
    check("R1 frm", 32'(frm_o), 1);
    check("R1 tx_ready", 32'(tx_ready), 0);
    check("R1 rx_valid", 32'(rx_valid), 0);
    check("R1 sdo_en", 32'(sdo_en), 0);
  endtask

  task automatic t_prescale;
    wr(2'd2, 16'h0005); rd_chk("R5 odd", 2'd2, 16'h0004);
    wr(2'd2, 16'h0001); rd_chk("R5 zero", 2'd2, 16'h0004);
    wr(2'd2, 16'h00FF); rd_chk("R5 max", 2'd2, 16'h00FE);
  endtask

  task automatic t_frozen;
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h1234);
    wr(2'd2, 16'h0006);
    wr(2'd1, 16'h0002);
    wr(2'd0, 16'hFFFF);
    wr(2'd2, 16'h000A);
    wr(2'd1, 16'h000E);
    rd_chk("R6 fmt", 2'd0, 16'h1234);
    rd_chk("R6 psc", 2'd2, 16'h0006);
    rd_chk("R6 mode", 2'd1, 16'h0002);
    check("R10 ready when enabled", 32'(tx_ready), 1);
    wr(2'd1, 16'h0000);
    rd_chk("R6 disable", 2'd1, 16'h0000);
  endtask

  task automatic run_master(input string tag, input logic [1:0] fmt, input logic pol, ph,
                            input logic [3:0] dss, input logic [7:0] ps, rate,
                            input logic [15:0] txw, rxw);
    int n = (dss < 3) ? 4 : int'(dss) + 1;
    int lead = (fmt == 2'b01) ? 2 : 0;
    logic epol = (fmt == 2'b01) ? 1'b0 : pol;
    int eph = (fmt == 2'b01) ? 1 : int'(ph);
    int half = (int'(ps) / 2) * (int'(rate) + 1);
    logic [16:0] m = (17'd1 << n) - 17'd1;
    logic [15:0] got = '0;
    int e = 0, since = 0, frm_hi = 0, half_meas = -1;
    bit sel_bad = 0;
    logic prev;
    wr(2'd1, 16'h0000);
    wr(2'd2, {8'h00, ps});
    wr(2'd0, {rate, ph, pol, fmt, dss});
    wr(2'd1, 16'h0002);
    check({tag, " R3 idle level"}, 32'(sclk_o), 32'(epol));
    sdi = rxw[n-1];
    @(negedge clk);
    tx_valid = 1'b1; tx_data = txw;
    @(negedge clk);
    tx_valid = 1'b0;
    prev = sclk_o;
    for (int c = 0; c < 6000 && !rx_valid; c++) begin
      @(negedge clk);
      since++;
      if (frm_o) frm_hi++;
      if (sclk_o !== prev) begin
        prev = sclk_o;
        if (e == 1) half_meas = since;
        since = 0;
        if (fmt != 2'b01 && frm_o !== 1'b0) sel_bad = 1;
        if (e >= lead) begin
          int j = e - lead;
          if ((j % 2) == eph) got = {got[14:0], sdo};
          else if ((j + 1) / 2 < n) sdi = rxw[n - 1 - (j + 1) / 2];
        end
        e++;
      end
    end
    check({tag, " R4 edges"}, 32'(e), 32'(2 * n + lead));
    check({tag, " R2 half period"}, 32'(half_meas), 32'(half));
    check({tag, " R3 sdo bits"}, 32'(got), 32'(txw & m[15:0]));
    check({tag, " R3 rx word"}, 32'(rx_data), 32'(rxw & m[15:0]));
    check({tag, " R3 clock back idle"}, 32'(sclk_o), 32'(epol));
    if (fmt == 2'b01) check({tag, " R7 strobe width"}, 32'(frm_hi), 32'(2 * half));
    else begin
      check({tag, " R3 select low"}, 32'(sel_bad), 0);
      check({tag, " R3 select idle"}, 32'(frm_o), 1);
    end
    repeat (3) @(negedge clk);
    check({tag, " R10 rx held"}, 32'(rx_valid), 1);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    check({tag, " R10 rx taken"}, 32'(rx_valid), 0);
  endtask

  task automatic run_slave(input string tag, input logic od, pol, ph, input logic [3:0] dss,
                           input logic [15:0] txw, rxw);
    int n = int'(dss) + 1;
    logic [16:0] m = (17'd1 << n) - 17'd1;
    logic [15:0] got = '0;
    bit en_bad = 0;
    frm_i = 1'b1; sclk_i = pol;
    wr(2'd1, {12'h000, od, 1'b1, 2'b00});
    wr(2'd0, {8'h00, ph, pol, 2'b00, dss});
    wr(2'd1, {12'h000, od, 1'b1, 2'b10});
    @(negedge clk);
    tx_valid = 1'b1; tx_data = txw;
    @(negedge clk);
    tx_valid = 1'b0;
    repeat (8) @(negedge clk);
    frm_i = 1'b0; sdi = rxw[n-1];
    for (int e = 0; e < 2 * n; e++) begin
      repeat (8) @(negedge clk);
      if (sdo_en !== !od) en_bad = 1;
      if ((e % 2) == int'(ph)) got = {got[14:0], sdo};
      sclk_i = ~sclk_i;
      if ((e % 2) != int'(ph) && (e + 1) / 2 < n) sdi = rxw[n - 1 - (e + 1) / 2];
    end
    repeat (8) @(negedge clk);
    frm_i = 1'b1;
    if (od) begin
      check({tag, " R9 driver off"}, 32'(en_bad), 0);
      check({tag, " R9 rx valid"}, 32'(rx_valid), 1);
      check({tag, " R9 rx word"}, 32'(rx_data), 32'(rxw & m[15:0]));
    end else begin
      check({tag, " R8 driver on"}, 32'(en_bad), 0);
      check({tag, " R8 sdo bits"}, 32'(got), 32'(txw & m[15:0]));
      check({tag, " R8 rx word"}, 32'(rx_data), 32'(rxw & m[15:0]));
      check({tag, " R8 driver off after"}, 32'(sdo_en), 0);
    end
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  initial begin
    n_chk = 0; n_bad = 0; finished = 0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    tx_valid = 1'b0; tx_data = '0; rx_ready = 1'b0;
    sclk_i = 1'b0; frm_i = 1'b1; sdi = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prescale();
    run_master("spi p1h1 8b", 2'b00, 1'b1, 1'b1, 4'd7, 8'd2, 8'd9, 16'h00A5, 16'h003C);
    run_master("spi p0h0 16b", 2'b00, 1'b0, 1'b0, 4'd15, 8'd4, 8'd0, 16'hBEEF, 16'h1357);
    run_master("spi short", 2'b00, 1'b0, 1'b1, 4'd1, 8'd6, 8'd2, 16'h00FB, 16'h0006);
    run_master("R7 code3 as spi", 2'b11, 1'b1, 1'b0, 4'd4, 8'd2, 8'd1, 16'h0015, 16'h000A);
    run_master("R7 pulsed", 2'b01, 1'b1, 1'b0, 4'd7, 8'd2, 8'd2, 16'h0069, 16'h00C3);
    t_frozen();
    run_slave("slave h0", 1'b0, 1'b0, 1'b0, 4'd7, 16'h005A, 16'h0096);
    run_slave("slave od", 1'b1, 1'b1, 1'b1, 4'd11, 16'h0ABC, 16'h0421);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule